// File: doc/BRIEF.md
# Test Access Port with Boundary Scan

This block is a serial test port built on the standard four-wire test protocol. A 16-state controller follows the mode-select line on each rising edge of the test clock. It routes a 3-bit instruction register or one of three data registers between the serial input and the serial output. The data registers are a one-bit pass-through register, a 32-bit identity word and a boundary chain that covers every pin of the core. During normal operation the core's outputs and output enables pass straight to the pads. The loaded instruction can instead make the pads take their values from the boundary chain, or release them to high impedance.

The boundary chain has a shift stage and a separate hold stage. Bits move through the shift stage while data is scanned. The hold stage changes only on the falling clock edge in the data-update state, so the pads never see partial scan data. In the chain, the pin inputs are nearest the serial output, followed by the output-data cells and then the output-enable cells. The reset input is synchronous and active high. The mode-select sequence gives a second way to return to the reset state.

Top module: `jtag_tap_bscan`

## Requirements
- R1: The controller follows the standard 16-state transition graph on each rising edge of `tck`. Five rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: While `tap_rst` is high at a rising edge, the controller enters Test-Logic-Reset. In Test-Logic-Reset the effective instruction is IDCODE (3'b001).
- R3: In Capture-IR the instruction shift stage loads 3'b001. It shifts out least significant bit first, so the serial output reads 1, 0, 0.
- R4: Under IDCODE, Capture-DR loads the 32-bit word {version[3:0], part[15:0], maker[10:0], 1'b1}, and Shift-DR sends it out least significant bit first.
- R5: Under BYPASS (3'b111), and under the unused codes 3'b101 and 3'b110, the data path is a single bit that captures 0. The serial output then repeats the serial input one shift later.
- R6: Under SAMPLE/PRELOAD (3'b010), Capture-DR loads {core_oe, core_out, pin_in} into the chain, with bit 0 nearest `tdo`, and the pads keep following the core.
- R7: Under EXTEST (3'b000), the chain captures the same fields as under R6. The pads carry the hold stage: pad_out from chain bits [NUM_IN +: NUM_OUT] and pad_oe from the bits above them, as loaded by the last Update-DR or preload.
- R8: Under CLAMP (3'b011), the pads carry the hold stage and keep it for the whole instruction, whatever the core does, and the data path is the one-bit register.
- R9: Under HIGHZ (3'b100), every pad_oe bit is 0, and the data path is the one-bit register.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R11: Under EXTEST, the pads stay constant while the chain shifts, and change only after Update-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high reset to Test-Logic-Reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo |
| pin_in | input | NUM_IN | Pad input values, as seen by the core |
| core_out | input | NUM_OUT | Functional output values from the core |
| core_oe | input | NUM_OUT | Functional output enables from the core |
| pad_out | output | NUM_OUT | Values driven to the output pads |
| pad_oe | output | NUM_OUT | Enables driven to the output pads |

## Verification
The properties assume that `tap_rst` is high at the first rising edge, so the controller state and the falling-edge registers are defined before any check is enabled. The CLAMP and EXTEST stability properties also assume that no instruction change reaches the pads unless the controller passes through Update-IR or Test-Logic-Reset. The stimulus meets both assumptions: it opens with a reset and changes the instruction only through complete IR scans or five-high sequences. It also drives `tms` and `tdi` one time unit after each falling edge, so they are stable at every rising edge.

// File: rtl/jtag_bscan_pkg.sv
`timescale 1ns/1ps
package jtag_bscan_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int IR_W = 3;
    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST = 3'b000;
    localparam opcode_t OP_IDCODE = 3'b001;
    localparam opcode_t OP_SAMPLE = 3'b010;
    localparam opcode_t OP_CLAMP  = 3'b011;
    localparam opcode_t OP_HIGHZ  = 3'b100;
    localparam opcode_t OP_BYPASS = 3'b111;
    localparam opcode_t IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUND} dr_sel_e;
    typedef enum logic [1:0] {PIN_CORE, PIN_SCAN, PIN_FLOAT} pin_mode_e;

    typedef struct packed {
        dr_sel_e   dr;
        pin_mode_e pins;
    } decode_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            ST_TLR:    return m ? ST_TLR    : ST_RTI;
            ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: return m ? ST_SEL_DR : ST_RTI;
            default:   return ST_TLR;
        endcase
    endfunction

    function automatic decode_t decode_op(input opcode_t op);
        decode_t d;
        case (op)
            OP_EXTEST: d = '{dr: DR_BOUND,  pins: PIN_SCAN};
            OP_SAMPLE: d = '{dr: DR_BOUND,  pins: PIN_CORE};
            OP_IDCODE: d = '{dr: DR_IDENT,  pins: PIN_CORE};
            OP_CLAMP:  d = '{dr: DR_BYPASS, pins: PIN_SCAN};
            OP_HIGHZ:  d = '{dr: DR_BYPASS, pins: PIN_FLOAT};
            default:   d = '{dr: DR_BYPASS, pins: PIN_CORE};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
    import jtag_bscan_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= ST_TLR;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/jtag_ir.sv
`timescale 1ns/1ps
module jtag_ir
    import jtag_bscan_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    output opcode_t    op_eff,
    output logic       ir_tdo
);
    opcode_t sh_q;
    opcode_t hold_q;

    always_ff @(posedge tck) begin
        if (rst)                     sh_q <= IR_CAPTURE;
        else if (state == ST_CAP_IR) sh_q <= IR_CAPTURE;
        else if (state == ST_SH_IR)  sh_q <= {tdi, sh_q[IR_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (rst || state == ST_TLR)  hold_q <= OP_IDCODE;
        else if (state == ST_UPD_IR) hold_q <= sh_q;
    end

    assign op_eff = (state == ST_TLR) ? OP_IDCODE : hold_q;
    assign ir_tdo = sh_q[0];
endmodule

// File: rtl/jtag_id_bypass.sv
`timescale 1ns/1ps
module jtag_id_bypass
    import jtag_bscan_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h0,
    parameter logic [15:0] ID_PART    = 16'h0001,
    parameter logic [10:0] ID_MAKER   = 11'b00010100001
) (
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  dr_sel_e    sel,
    input  logic       tdi,
    output logic       id_tdo,
    output logic       byp_tdo
);
    localparam int ID_W = 32;
    localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    logic [ID_W-1:0] id_q;
    logic            byp_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            id_q  <= ID_WORD;
            byp_q <= 1'b0;
        end else begin
            if (sel == DR_IDENT) begin
                if (state == ST_CAP_DR)     id_q <= ID_WORD;
                else if (state == ST_SH_DR) id_q <= {tdi, id_q[ID_W-1:1]};
            end
            if (sel == DR_BYPASS) begin
                if (state == ST_CAP_DR)     byp_q <= 1'b0;
                else if (state == ST_SH_DR) byp_q <= tdi;
            end
        end
    end

    assign id_tdo  = id_q[0];
    assign byp_tdo = byp_q;
endmodule

// File: rtl/jtag_bsr.sv
`timescale 1ns/1ps
module jtag_bsr
    import jtag_bscan_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4
) (
    input  logic               tck,
    input  logic               rst,
    input  tap_state_e         state,
    input  logic               sel,
    input  logic               tdi,
    input  logic [NUM_IN-1:0]  pin_in,
    input  logic [NUM_OUT-1:0] core_out,
    input  logic [NUM_OUT-1:0] core_oe,
    output logic               bsr_tdo,
    output logic [NUM_OUT-1:0] hold_out,
    output logic [NUM_OUT-1:0] hold_oe
);
    localparam int LEN    = NUM_IN + 2 * NUM_OUT;
    localparam int HOLD_W = 2 * NUM_OUT;

    logic [LEN-1:0]    sh_q;
    logic [HOLD_W-1:0] hold_q;

    always_ff @(posedge tck) begin
        if (rst)                            sh_q <= '0;
        else if (sel && state == ST_CAP_DR) sh_q <= {core_oe, core_out, pin_in};
        else if (sel && state == ST_SH_DR)  sh_q <= {tdi, sh_q[LEN-1:1]};
    end

    always_ff @(negedge tck) begin
        if (rst)                            hold_q <= '0;
        else if (sel && state == ST_UPD_DR) hold_q <= sh_q[LEN-1:NUM_IN];
    end

    assign bsr_tdo  = sh_q[0];
    assign hold_out = hold_q[NUM_OUT-1:0];
    assign hold_oe  = hold_q[HOLD_W-1:NUM_OUT];
endmodule

// File: rtl/jtag_tap_bscan.sv
`timescale 1ns/1ps
module jtag_tap_bscan
    import jtag_bscan_pkg::*;
#(
    parameter int          NUM_IN     = 4,
    parameter int          NUM_OUT    = 4,
    parameter logic [3:0]  ID_VERSION = 4'h0,
    parameter logic [15:0] ID_PART    = 16'h0001,
    parameter logic [10:0] ID_MAKER   = 11'b00010100001
) (
    input  logic               tck,
    input  logic               tap_rst,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic [NUM_IN-1:0]  pin_in,
    input  logic [NUM_OUT-1:0] core_out,
    input  logic [NUM_OUT-1:0] core_oe,
    output logic [NUM_OUT-1:0] pad_out,
    output logic [NUM_OUT-1:0] pad_oe
);
    tap_state_e         state;
    opcode_t            op_eff;
    decode_t            dec;
    logic               ir_tdo, id_tdo, byp_tdo, bsr_tdo, dr_tdo;
    logic [NUM_OUT-1:0] hold_out, hold_oe;

    jtag_tap_fsm u_fsm (.tck(tck), .rst(tap_rst), .tms(tms), .state(state));

    jtag_ir u_ir (
        .tck(tck), .rst(tap_rst), .state(state), .tdi(tdi),
        .op_eff(op_eff), .ir_tdo(ir_tdo)
    );

    assign dec = decode_op(op_eff);

    jtag_id_bypass #(
        .ID_VERSION(ID_VERSION), .ID_PART(ID_PART), .ID_MAKER(ID_MAKER)
    ) u_idb (
        .tck(tck), .rst(tap_rst), .state(state), .sel(dec.dr), .tdi(tdi),
        .id_tdo(id_tdo), .byp_tdo(byp_tdo)
    );

    jtag_bsr #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_bsr (
        .tck(tck), .rst(tap_rst), .state(state), .sel(dec.dr == DR_BOUND),
        .tdi(tdi), .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
        .bsr_tdo(bsr_tdo), .hold_out(hold_out), .hold_oe(hold_oe)
    );

    always_comb begin
        case (dec.dr)
            DR_IDENT: dr_tdo = id_tdo;
            DR_BOUND: dr_tdo = bsr_tdo;
            default:  dr_tdo = byp_tdo;
        endcase
    end

    always_ff @(negedge tck) begin
        if (tap_rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == ST_SH_IR) ? ir_tdo : dr_tdo;
            tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
        end
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pad
        assign pad_out[i] = (dec.pins == PIN_SCAN) ? hold_out[i] : core_out[i];
        assign pad_oe[i]  = (dec.pins == PIN_SCAN)  ? hold_oe[i] :
                            (dec.pins == PIN_FLOAT) ? 1'b0       : core_oe[i];
    end
endmodule

// File: rtl/jtag_tap_bscan_chk.sv
`timescale 1ns/1ps
module jtag_tap_bscan_chk
    import jtag_bscan_pkg::*;
#(
    parameter int NUM_OUT = 4
) (
    input logic               tck,
    input logic               tap_rst,
    input logic               tms,
    input logic               tdo_oe,
    input tap_state_e         state,
    input opcode_t            op_eff,
    input logic [NUM_OUT-1:0] pad_out,
    input logic [NUM_OUT-1:0] pad_oe
);
    assert_rst_to_tlr_R2: assert property (@(posedge tck) disable iff (tap_rst)
        $past(tap_rst) |-> state == ST_TLR);

    assert_five_tms_high_R1: assert property (@(posedge tck) disable iff (tap_rst)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> state == ST_TLR);

    assert_oe_shift_only_R10: assert property (@(posedge tck) disable iff (tap_rst)
        tdo_oe == (state == ST_SH_DR || state == ST_SH_IR));

    assert_highz_float_R9: assert property (@(posedge tck) disable iff (tap_rst)
        (op_eff == OP_HIGHZ) |-> pad_oe == '0);

    assert_clamp_hold_R8: assert property (@(negedge tck) disable iff (tap_rst)
        (op_eff == OP_CLAMP && $past(op_eff == OP_CLAMP))
        |-> ($stable(pad_out) && $stable(pad_oe)));

    assert_extest_shift_stable_R11: assert property (@(posedge tck) disable iff (tap_rst)
        (op_eff == OP_EXTEST && state == ST_SH_DR &&
         $past(op_eff == OP_EXTEST && state == ST_SH_DR))
        |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind jtag_tap_bscan jtag_tap_bscan_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdo_oe(tdo_oe),
    .state(state), .op_eff(op_eff), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/jtag_tap_bscan_test.sv
`timescale 1ns/1ps
module jtag_tap_bscan_test;
    localparam int NI = 4;
    localparam int NO = 4;
    localparam int LEN = NI + 2 * NO;
    localparam logic [3:0]  VER   = 4'h0;
    localparam logic [15:0] PART  = 16'h0001;
    localparam logic [10:0] MAKER = 11'b00010100001;

    logic tck = 1'b0;
    logic tap_rst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe;
    logic [NI-1:0] pin_in = '0;
    logic [NO-1:0] core_out = '0, core_oe = '0;
    logic [NO-1:0] pad_out, pad_oe;

    int tests = 0, fails = 0, edge_bad = 0, oe_bad = 0, hold_bad = 0;

    always #2 tck = ~tck;

    jtag_tap_bscan #(.NUM_IN(NI), .NUM_OUT(NO), .ID_VERSION(VER),
                     .ID_PART(PART), .ID_MAKER(MAKER)) uut (
        .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_oe(tdo_oe), .pin_in(pin_in), .core_out(core_out),
        .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [63:0] id_expected();
        logic [63:0] v;
        v = 64'd1;
        v = v + (64'(MAKER) << 1);
        v = v + (64'(PART) << 12);
        v = v + (64'(VER) << 28);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic oe);
        @(negedge tck); #1;
        o = tdo; oe = tdo_oe;
        tms = m; tdi = d;
        @(posedge tck); #0.5;
        if (tdo !== o) edge_bad++;
    endtask

    task automatic settle();
        @(negedge tck); #1;
    endtask

    task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap);
        logic o, oe;
        step(1, 0, o, oe); step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, op[i], o, oe);
            cap[i] = o;
            if (oe !== 1'b1) oe_bad++;
        end
        step(1, 0, o, oe); step(0, 0, o, oe);
    endtask

    task automatic scan_dr(input logic [63:0] din, input int n, input bit hold,
                           output logic [63:0] dout);
        logic o, oe;
        logic [NO-1:0] p0, e0;
        dout = '0;
        step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
        p0 = pad_out; e0 = pad_oe;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, oe);
            dout[i] = o;
            if (oe !== 1'b1) oe_bad++;
            if (hold && (pad_out !== p0 || pad_oe !== e0)) hold_bad++;
        end
        step(1, 0, o, oe); step(0, 0, o, oe);
    endtask

    task automatic do_reset();
        logic o, oe;
        tap_rst = 1'b1;
        step(1, 0, o, oe); step(1, 0, o, oe);
        @(negedge tck); #1;
        tap_rst = 1'b0; tms = 1'b0;
        @(posedge tck);
    endtask

    task automatic check_core_pads(input string req);
        settle();
        check(pad_out === core_out && pad_oe === core_oe, req, "pads follow core",
              {pad_oe, pad_out}, {core_oe, core_out});
    endtask

    task automatic check_bypass(input string req, input logic [15:0] pat);
        logic [63:0] r;
        scan_dr(64'(pat), 16, 0, r);
        check(r[15:0] === {pat[14:0], 1'b0}, req, "one-bit data path",
              r, 64'({pat[14:0], 1'b0}));
    endtask

    initial begin
        logic [2:0] cap;
        logic [63:0] r, q, exp;
        logic o, oe;
        do_reset();

        // R2: reset state
        settle();
        check(tdo_oe === 1'b0, "R2", "tdo_oe low after reset", 64'(tdo_oe), 64'd0);
        check(pad_out === core_out && pad_oe === core_oe, "R2", "pads in core mode",
              {pad_oe, pad_out}, {core_oe, core_out});
        // R4: identity word after reset
        scan_dr('0, 32, 0, r);
        check(r[31:0] === id_expected()[31:0], "R4", "id word after reset", r, id_expected());
        check(r[0] === 1'b1, "R4", "id bit 0", 64'(r[0]), 64'd1);
        // R3: capture pattern
        scan_ir(3'b001, cap);
        check(cap === 3'b001, "R3", "IR capture bits", 64'(cap), 64'd1);
        settle();
        check(tdo_oe === 1'b0, "R10", "tdo_oe low in idle", 64'(tdo_oe), 64'd0);

        // R1: five-high sequence after walks through many states
        for (int pat = 0; pat < 32; pat++) begin
            scan_ir(3'b111, cap);
            for (int b = 0; b < 5; b++) step(pat[b], 0, o, oe);
            for (int b = 0; b < 5; b++) step(1, 0, o, oe);
            step(0, 0, o, oe);
            scan_dr('0, 32, 0, r);
            check(r[31:0] === id_expected()[31:0], "R1", $sformatf("walk %0d then TLR", pat),
                  r, id_expected());
        end

        // R5: bypass and unused codes
        for (int k = 5; k < 8; k++) begin
            scan_ir(3'(k), cap);
            check_bypass("R5", 16'hA5C3 ^ 16'(k * 16'h1111));
        end

        // R6: sample sweep
        scan_ir(3'b010, cap);
        for (int v = 0; v < 16; v++) begin
            pin_in = 4'(v); core_out = 4'(v ^ 9); core_oe = 4'(v * 3);
            scan_dr('0, LEN, 0, r);
            exp = 64'({core_oe, core_out, pin_in});
            check(r[LEN-1:0] === exp[LEN-1:0], "R6", $sformatf("sample capture %0d", v), r, exp);
            check_core_pads("R6");
        end

        // R7: preload then EXTEST
        scan_dr(64'({4'b1010, 4'b0110, 4'b0000}), LEN, 0, r);
        scan_ir(3'b000, cap);
        settle();
        check(pad_out === 4'b0110 && pad_oe === 4'b1010, "R7", "preloaded pads",
              {pad_oe, pad_out}, 8'b1010_0110);
        q = '0;
        for (int v = 0; v < 6; v++) begin
            pin_in = 4'(v + 3); core_out = 4'(v * 5); core_oe = 4'(~v);
            q = 64'({4'(v * 7 + 1), 4'(v ^ 12), 4'(v)});
            scan_dr(q, LEN, 1, r);
            exp = 64'({core_oe, core_out, pin_in});
            check(r[LEN-1:0] === exp[LEN-1:0], "R7", "extest capture", r, exp);
            settle();
            check(pad_out === q[NI +: NO] && pad_oe === q[NI+NO +: NO], "R7",
                  "pads after update", {pad_oe, pad_out}, {q[NI+NO +: NO], q[NI +: NO]});
        end
        check(hold_bad == 0, "R11", "pads steady while shifting", 64'(hold_bad), 64'd0);

        // R8: clamp keeps last update stage
        scan_ir(3'b011, cap);
        settle();
        check(pad_out === q[NI +: NO] && pad_oe === q[NI+NO +: NO], "R8", "clamp pads",
              {pad_oe, pad_out}, {q[NI+NO +: NO], q[NI +: NO]});
        core_out = ~core_out; core_oe = ~core_oe;
        check_bypass("R8", 16'h3C5A);
        settle();
        check(pad_out === q[NI +: NO] && pad_oe === q[NI+NO +: NO], "R8", "clamp held",
              {pad_oe, pad_out}, {q[NI+NO +: NO], q[NI +: NO]});

        // R9: highz
        scan_ir(3'b100, cap);
        core_oe = 4'hF;
        settle();
        check(pad_oe === 4'b0000, "R9", "pad_oe released", 64'(pad_oe), 64'd0);
        check_bypass("R9", 16'h9F06);

        // back to bypass then reset mid-instruction
        scan_ir(3'b111, cap);
        check_core_pads("R5");
        scan_ir(3'b000, cap);
        do_reset();
        check_core_pads("R2");
        scan_dr('0, 32, 0, r);
        check(r[31:0] === id_expected()[31:0], "R2", "IDCODE after reset", r, id_expected());

        check(edge_bad == 0, "R10", "tdo steady across rising edges", 64'(edge_bad), 64'd0);
        check(oe_bad == 0, "R10", "tdo_oe high in shift", 64'(oe_bad), 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule